// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Aggregation

This block is the register bank of a serial port on a simple word-addressed CPU bus. It decodes each access by word index. It holds the baud divisor pair, the line-control, control, FIFO-level, IrDA low-power and DMA-control words. It keeps the receive status nibble and the interrupt state: raw status, enable mask, masked view and a write-only clear port. It also exposes eight fixed identification bytes at the top of the address window. The serializer and the receive buffer sit outside the block. The bank reaches them through a transmit strobe, a pop strobe, the receive word and flag inputs, a receive-interrupt level and a vector of event pulses.

All eleven interrupt sources are combined into one registered interrupt line. A data-register write sends the low byte to the serializer and raises the transmit source. A data-register read pops the receive buffer and latches the error nibble that came with the byte. The receive source is owned by the buffer. The bank latches it on the buffer's rising edge and drops it when the buffer drops its level.

Top module: `uart_regbank`

## Requirements
- R1: After synchronous reset, index 12 (control) reads 0x300 and index 13 (FIFO level select) reads 0x12. Indices 8, 9, 10, 11, 14, 15 and 18 read zero, and `irq` is low.
- R2: Indices 8, 9, 10, 11, 12, 13 and 18 store the full written word. A read returns it in `bus_rdata` on the cycle after the access, with no other effect.
- R3: An access to an undecoded index returns zero and raises `bus_err` for exactly one cycle. A write to such an index changes no register. Indices 0, 1, 6 and 8–18 are decoded, and so are 1016–1023.
- R4: A write to index 0 pulses `tx_valid` for one cycle with `tx_byte` equal to bits 7:0 of the written word. It also sets raw interrupt bit 5 (transmit).
- R5: A read of index 0 returns `rx_word` zero-extended and pulses `rx_rd` for one cycle. It also loads bits 11:8 of `rx_word` into the receive status register, which index 1 reads.
- R6: Any write to index 1 clears the receive status register to zero.
- R7: Index 14 holds the 11-bit interrupt mask and index 15 reads the raw status. Index 16 reads raw AND mask. The bit map is: bits 0–3 modem, 4 receive, 5 transmit, 6 receive timeout, 7–10 line errors.
- R8: A write to index 17 clears each raw bit where the written word has a one. Index 17 reads as zero.
- R9: `irq` is high exactly when, on the previous cycle, raw AND mask was non-zero in bits 0–10.
- R10: A pulse on `evt_set` sets raw bits 0–3 and 6–10. Its bits 4 and 5 are ignored. If an event and a clear of the same bit fall in one cycle, the event wins.
- R11: Raw bit 4 is set on a rising edge of `rx_irq` and drops whenever `rx_irq` is low. A clear of bit 4 while `rx_irq` stays high keeps it low until the next rising edge.
- R12: Indices 1016 to 1023 read, in order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R13: Index 6 returns `rx_flags` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the access |
| bus_err | output | 1 | One-cycle error for an undecoded index |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Byte for the serializer |
| rx_rd | output | 1 | Pop strobe to the receive buffer |
| rx_word | input | 12 | Head of receive buffer: error nibble in 11:8, data in 7:0 |
| rx_flags | input | 8 | Buffer and line flags shown at index 6 |
| rx_irq | input | 1 | Receive-interrupt level from the buffer |
| evt_set | input | NSRC | Per-source event pulses |
| irq | output | 1 | Combined interrupt |

## Verification
Two raw-status updates can land in the same cycle: an event pulse and a clear-register write that targets the same bit. The bench drives `evt_set` bit 0 in the cycle where it writes a one to bit 0 of index 17. It then reads index 15 and expects bit 0 still set. A second collision is a clear of bit 4 while the buffer holds `rx_irq` high. The bench expects the bit to stay low until `rx_irq` falls and rises again.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int NSRC     = 11;
  localparam int BIT_RX   = 4;
  localparam int BIT_TX   = 5;
  localparam int ID_BASE  = 1016;
  localparam int ID_COUNT = 8;

  typedef enum logic [3:0] {
    K_NONE, K_DATA, K_RSR, K_FLAG, K_ILP, K_IBD, K_FBD, K_LCR,
    K_CR, K_IFL, K_MASK, K_RAW, K_MIS, K_CLR, K_DMA, K_ID
  } reg_kind_e;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_regbank_dec.sv
module uart_regbank_dec
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  always_comb begin
    kind = K_NONE;
    if (int'(addr) >= ID_BASE && int'(addr) < ID_BASE + ID_COUNT) kind = K_ID;
    else begin
      case (int'(addr))
        0:  kind = K_DATA;
        1:  kind = K_RSR;
        6:  kind = K_FLAG;
        8:  kind = K_ILP;
        9:  kind = K_IBD;
        10: kind = K_FBD;
        11: kind = K_LCR;
        12: kind = K_CR;
        13: kind = K_IFL;
        14: kind = K_MASK;
        15: kind = K_RAW;
        16: kind = K_MIS;
        17: kind = K_CLR;
        18: kind = K_DMA;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
  import uart_regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wd,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_wd,
  input  logic            tx_set,
  input  logic [NSRC-1:0] evt_set,
  input  logic            rx_lvl,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  logic            rx_prev;
  logic [NSRC-1:0] clr_v, set_v, raw_nx;

  always_comb begin
    clr_v = clr_we ? clr_wd : '0;
    set_v = evt_set;
    set_v[BIT_RX] = 1'b0;
    set_v[BIT_TX] = tx_set;
    raw_nx = (raw & ~clr_v) | set_v;
    raw_nx[BIT_RX] = (rx_lvl & ~rx_prev) | (raw[BIT_RX] & rx_lvl & ~clr_v[BIT_RX]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw     <= '0;
      mask    <= '0;
      irq     <= 1'b0;
      rx_prev <= 1'b0;
    end else begin
      raw     <= raw_nx;
      rx_prev <= rx_lvl;
      irq     <= |(raw & mask);
      if (mask_we) mask <= mask_wd;
    end
  end

  // R10: an event always lands, even against a clear in the same cycle
  a_r10_event_sets: assert property (@(posedge clk) disable iff (rst)
    evt_set[0] |=> raw[0]);
  // R8: a clear with no competing event removes the bit
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_wd[0] && !evt_set[0]) |=> !raw[0]);
  // R11: receive bit cannot be set unless the buffer level was high
  a_r11_rx_needs_level: assert property (@(posedge clk) disable iff (rst)
    raw[BIT_RX] |-> rx_prev);
  // R9: the line only rises while some enabled source exists
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mask != '0));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              rx_rd,
  input  logic [11:0]       rx_word,
  input  logic [7:0]        rx_flags,
  input  logic              rx_irq,
  input  logic [NSRC-1:0]   evt_set,
  output logic              irq
);
  localparam logic [DATA_W-1:0] CR_RST  = DATA_W'(32'h300);
  localparam logic [DATA_W-1:0] IFL_RST = DATA_W'(32'h12);

  reg_kind_e         kind;
  logic              wr_acc, rd_acc;
  logic [DATA_W-1:0] ilp_q, ibd_q, fbd_q, lcr_q, cr_q, ifl_q, dma_q, rd_nx;
  logic [3:0]        rsr_q;
  logic [NSRC-1:0]   raw, mask;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  uart_regbank_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .kind(kind));

  uart_regbank_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .mask_we (wr_acc && kind == K_MASK),
    .mask_wd (bus_wdata[NSRC-1:0]),
    .clr_we  (wr_acc && kind == K_CLR),
    .clr_wd  (bus_wdata[NSRC-1:0]),
    .tx_set  (wr_acc && kind == K_DATA),
    .evt_set (evt_set),
    .rx_lvl  (rx_irq),
    .raw     (raw),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    case (kind)
      K_DATA:  rd_nx = DATA_W'(rx_word);
      K_RSR:   rd_nx = DATA_W'(rsr_q);
      K_FLAG:  rd_nx = DATA_W'(rx_flags);
      K_ILP:   rd_nx = ilp_q;
      K_IBD:   rd_nx = ibd_q;
      K_FBD:   rd_nx = fbd_q;
      K_LCR:   rd_nx = lcr_q;
      K_CR:    rd_nx = cr_q;
      K_IFL:   rd_nx = ifl_q;
      K_MASK:  rd_nx = DATA_W'(mask);
      K_RAW:   rd_nx = DATA_W'(raw);
      K_MIS:   rd_nx = DATA_W'(raw & mask);
      K_DMA:   rd_nx = dma_q;
      K_ID:    rd_nx = DATA_W'(id_byte(bus_addr[2:0]));
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ilp_q <= '0; ibd_q <= '0; fbd_q <= '0; lcr_q <= '0;
      cr_q  <= CR_RST; ifl_q <= IFL_RST; dma_q <= '0;
      rsr_q <= '0;
      bus_rdata <= '0; bus_err <= 1'b0;
      tx_valid <= 1'b0; tx_byte <= '0; rx_rd <= 1'b0;
    end else begin
      bus_rdata <= rd_acc ? rd_nx : '0;
      bus_err   <= bus_sel && kind == K_NONE;
      tx_valid  <= wr_acc && kind == K_DATA;
      rx_rd     <= rd_acc && kind == K_DATA;
      if (wr_acc && kind == K_DATA) tx_byte <= bus_wdata[7:0];
      if (rd_acc && kind == K_DATA) rsr_q <= rx_word[11:8];
      if (wr_acc) begin
        case (kind)
          K_RSR: rsr_q <= '0;
          K_ILP: ilp_q <= bus_wdata;
          K_IBD: ibd_q <= bus_wdata;
          K_FBD: fbd_q <= bus_wdata;
          K_LCR: lcr_q <= bus_wdata;
          K_CR:  cr_q  <= bus_wdata;
          K_IFL: ifl_q <= bus_wdata;
          K_DMA: dma_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // R3: error only follows an access
  a_r3_err_after_access: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));
  // R4: transmit strobe only after a data write
  a_r4_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(wr_acc && bus_addr == '0));
  // R4: transmit strobe comes with the raw transmit bit
  a_r4_tx_raises_raw: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> raw[BIT_TX]);
  // R5: pop strobe only after a data read
  a_r5_pop_from_read: assert property (@(posedge clk) disable iff (rst)
    rx_rd |-> $past(rd_acc && bus_addr == '0));
  // R6: status write leaves zero
  a_r6_rsr_zeroed: assert property (@(posedge clk) disable iff (rst)
    $past(wr_acc && int'(bus_addr) == 1) |-> rsr_q == 4'd0);
endmodule

// File: tb/test_uart_regbank.sv
`timescale 1ns/1ps
module test_uart_regbank;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err, tx_valid, rx_rd, irq;
  logic [7:0]    tx_byte;
  logic [11:0]   rx_word = '0;
  logic [7:0]    rx_flags = '0;
  logic          rx_irq = 1'b0;
  logic [10:0]   evt_set = '0;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] s_rd;
  logic s_err, s_tx, s_pop;
  logic [7:0] s_byte;
  logic [DW-1:0] model [0:18];
  logic [10:0] m_raw, m_mask;
  logic done = 1'b0;

  always #10 clk = ~clk;

  uart_regbank #(.ADDR_W(AW), .DATA_W(DW)) i_uart_regbank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_rd(rx_rd), .rx_word(rx_word), .rx_flags(rx_flags),
    .rx_irq(rx_irq), .evt_set(evt_set), .irq(irq));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input int idx, input logic [DW-1:0] wd, input logic [10:0] ev);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = AW'(idx); bus_wdata = wd; evt_set = ev;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
    s_rd = bus_rdata; s_err = bus_err; s_tx = tx_valid; s_pop = rx_rd; s_byte = tx_byte;
  endtask

  task automatic pulse(input logic [10:0] ev);
    @(negedge clk); evt_set = ev;
    @(negedge clk); evt_set = '0;
  endtask

  function automatic logic [7:0] exp_id(input int k);
    logic [63:0] t = 64'hB105F00D00141011;
    return t[8*k +: 8];
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int idx_list [7] = '{8, 9, 10, 11, 12, 13, 18};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    for (int i = 0; i <= 18; i++) model[i] = '0;
    model[12] = 32'h300; model[13] = 32'h12;
    foreach (idx_list[k]) begin
      acc(1'b0, idx_list[k], '0, '0);
      chk("R1", s_rd, model[idx_list[k]]);
    end
    acc(1'b0, 14, '0, '0); chk("R1 mask", s_rd, 0);
    acc(1'b0, 15, '0, '0); chk("R1 raw", s_rd, 0);
    chk("R1 irq", DW'(irq), 0);

    // R13 flags
    rx_flags = 8'h90;
    acc(1'b0, 6, '0, '0); chk("R13", s_rd, 32'h90);

    // R2 random storage
    for (int it = 0; it < 150; it++) begin
      int ix = idx_list[$urandom_range(0, 6)];
      logic [DW-1:0] v = $urandom;
      acc(1'b1, ix, v, '0); model[ix] = v;
      acc(1'b0, ix, '0, '0); chk("R2", s_rd, model[ix]);
    end

    // R3 undecoded
    acc(1'b0, 3, '0, '0);
    chk("R3 rdata", s_rd, 0); chk("R3 err", DW'(s_err), 1);
    @(negedge clk); chk("R3 err one cycle", DW'(bus_err), 0);
    acc(1'b1, 19, 32'hDEAD, '0); chk("R3 write err", DW'(s_err), 1);
    acc(1'b1, 1015, 32'hBEEF, '0); chk("R3 write err hi", DW'(s_err), 1);
    acc(1'b0, 9, '0, '0); chk("R3 no effect", s_rd, model[9]);
    acc(1'b0, 16, '0, '0); chk("R3 decoded no err", DW'(s_err), 0);

    // R12 identification
    for (int k = 0; k < 8; k++) begin
      acc(1'b0, 1016 + k, '0, '0); chk("R12", s_rd, DW'(exp_id(k)));
    end

    // R4 transmit
    acc(1'b1, 0, 32'h1A5, '0);
    chk("R4 strobe", DW'(s_tx), 1); chk("R4 byte", DW'(s_byte), 32'hA5);
    @(negedge clk); chk("R4 one cycle", DW'(tx_valid), 0);
    acc(1'b0, 15, '0, '0); chk("R4 raw tx", s_rd, 32'h20);

    // R9 interrupt line
    chk("R9 masked off", DW'(irq), 0);
    acc(1'b1, 14, 32'h20, '0);
    @(negedge clk); chk("R9 irq up", DW'(irq), 1);
    acc(1'b0, 16, '0, '0); chk("R7 masked", s_rd, 32'h20);
    acc(1'b1, 17, 32'h20, '0);
    @(negedge clk); chk("R9 irq down", DW'(irq), 0);
    acc(1'b0, 17, '0, '0); chk("R8 write-only", s_rd, 0);

    // R10 events, bits 4 and 5 ignored
    pulse(11'h7FF);
    acc(1'b0, 15, '0, '0); chk("R10 set", s_rd, 32'h7CF);
    acc(1'b1, 17, 32'h7FF, '0);
    acc(1'b0, 15, '0, '0); chk("R8 clear all", s_rd, 0);
    acc(1'b1, 17, 32'h1, 11'h001);
    acc(1'b0, 15, '0, '0); chk("R10 set beats clear", s_rd, 32'h1);
    acc(1'b1, 17, 32'h1, '0);

    // R11 receive source
    @(negedge clk); rx_irq = 1'b1;
    @(negedge clk);
    acc(1'b0, 15, '0, '0); chk("R11 rise sets", s_rd, 32'h10);
    acc(1'b1, 17, 32'h10, '0);
    acc(1'b0, 15, '0, '0); chk("R11 clear holds", s_rd, 0);
    @(negedge clk); rx_irq = 1'b0;
    @(negedge clk); rx_irq = 1'b1;
    @(negedge clk);
    acc(1'b0, 15, '0, '0); chk("R11 re-rise", s_rd, 32'h10);
    rx_irq = 1'b0;
    @(negedge clk);
    acc(1'b0, 15, '0, '0); chk("R11 level drop", s_rd, 0);

    // R5 data read, R6 status clear
    rx_word = 12'hA5C;
    acc(1'b0, 0, '0, '0);
    chk("R5 data", s_rd, 32'hA5C); chk("R5 pop", DW'(s_pop), 1);
    acc(1'b0, 1, '0, '0); chk("R5 status", s_rd, 32'hA);
    acc(1'b1, 1, 32'hFFFF, '0);
    acc(1'b0, 1, '0, '0); chk("R6", s_rd, 0);

    // R7 random mask/raw
    m_raw = '0; m_mask = 11'h20;
    for (int it = 0; it < 40; it++) begin
      logic [10:0] ev = 11'($urandom);
      logic [10:0] mk = 11'($urandom);
      logic [10:0] cl = 11'($urandom);
      acc(1'b1, 14, DW'(mk), '0); m_mask = mk;
      pulse(ev); m_raw = m_raw | (ev & 11'h7CF);
      acc(1'b0, 15, '0, '0); chk("R7 raw", s_rd, DW'(m_raw));
      acc(1'b0, 16, '0, '0); chk("R7 masked", s_rd, DW'(m_raw & m_mask));
      acc(1'b0, 14, '0, '0); chk("R7 mask", s_rd, DW'(m_mask));
      @(negedge clk); chk("R9 random", DW'(irq), DW'(|(m_raw & m_mask)));
      acc(1'b1, 17, DW'(cl), '0); m_raw = m_raw & ~cl;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule